// File: doc/BRIEF.md
# Oversampling Serial Receiver with Standby Wake-Up

This block turns an asynchronous serial line into received characters. The line is resynchronised to the core clock and sampled on a sample strobe that pulses sixteen times per bit period. Each bit, including start and stop, is settled by a 2-of-3 vote over the three samples at the centre of the bit. A frame has one start bit, 8 or 9 data bits sent least significant bit first, and one stop bit. When the stop bit has been voted, the character moves into an output register and is offered on a valid/ready read port.

The read port follows a valid/ready pattern. `rd_valid` is the receive-full flag. A cycle with `rd_ready` high is a read: it empties the register and clears every error flag. The consumer can apply back-pressure by leaving `rd_ready` low. The receiver does not stall the line in that case. If another frame completes while `rd_valid` is still high, that frame is dropped, the stored character is kept and the overrun flag is raised.

For multi-drop links, a one-cycle `sleep_req` pulse puts the receiver into standby. In standby, received characters still overwrite the data register, but the full flag and the error flags do not change. Standby ends by itself after the line has stayed high, with no frame in progress, for one whole character time.

Top module: `serial_rx_ovs`

## Requirements
- R1: Every bit value is the majority of the samples taken at sample counts 8, 9 and 10, where count 1 is the first strobe that sees the start-bit falling edge and one bit spans 16 strobes. A single disagreeing sample therefore never changes a received bit.
- R2: A falling edge begins a start bit only if the start-bit vote is low. If the vote is high, the receiver goes back to hunting and reports nothing.
- R3: With `len9` low a frame carries 8 data bits and `rd_bit8` reads 0. With `len9` high it carries 9 data bits: the first 8 bits received go to `rd_data[7:0]`, least significant bit first, and the ninth goes to `rd_bit8`.
- R4: Outside standby, when a frame completes and the register is empty (or being read in the same cycle), its data is loaded and `rd_valid` rises.
- R5: `irq` is high exactly while `rie` and `rd_valid` are both high.
- R6: A break (all data bits 0 and a 0 stop bit) sets `err_frame` and `rd_valid` and leaves the data register at zero, including `rd_bit8`.
- R7: A stop bit voted 0 sets `err_frame` along with the data. A stop bit voted 1 leaves `err_frame` clear.
- R8: `err_noise` is set with a frame if the three samples of any of its bits disagreed. It stays clear when every bit's samples agree.
- R9: A frame that completes while `rd_valid` is high and no read is taking place sets `err_overrun` and leaves the stored character unchanged.
- R10: A cycle with `rd_ready` high clears `rd_valid`, `err_frame`, `err_overrun` and `err_noise`.
- R11: `rx_busy` is high from the accepted start edge until the stop bit has been voted, and is low while hunting.
- R12: After a `sleep_req` pulse, completed frames load the data register but change neither `rd_valid` nor the error flags.
- R13: Standby ends after (data bits + 2) x 16 consecutive strobes with the line high and no frame in progress. That is 160 strobes with `len9` low and 176 with it high. A low line restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| smp_tick | input | 1 | Sample strobe, 16 per bit period |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| sleep_req | input | 1 | Pulse that enters standby |
| rie | input | 1 | Interrupt enable for receive-full |
| rd_ready | input | 1 | Read strobe; empties the register and clears flags |
| rd_valid | output | 1 | Receive register holds an unread character |
| rd_data | output | 8 | Low eight data bits |
| rd_bit8 | output | 1 | Ninth data bit |
| err_frame | output | 1 | Stop bit was 0 |
| err_overrun | output | 1 | A frame was dropped because the register was full |
| err_noise | output | 1 | Samples within some bit disagreed |
| rx_busy | output | 1 | Frame reception in progress |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench places one-strobe glitches on samples 8, 9 and 10 and just outside them. A voter with a misplaced window would either corrupt data or miss the noise flag. Short low pulses check that a receiver which skips the start vote does not lock onto spikes. Back-to-back frames with no read check that an overrun keeps the old character rather than the new one. Breaks check that the data register clears and the framing flag is set. Standby is exercised with idle gaps just shorter and just longer than one character in both lengths, which exposes an idle count that ignores `len9` or is never restarted by a low line.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int RX_BASE_BITS = 8;
  localparam int RX_MAX_BITS  = RX_BASE_BITS + 1;
  localparam int RX_IDX_W     = $clog2(RX_MAX_BITS);

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic [RX_MAX_BITS-1:0] bits;
    logic                   stop_ok;
    logic                   noisy;
  } rx_frame_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_vote_unit.sv
module rx_vote_unit #(
  parameter int OVS = 16,
  parameter int CW  = $clog2(OVS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          in_bit,
  input  logic [CW-1:0] rt,
  input  logic          line,
  output logic          vote_stb,
  output logic          vote,
  output logic          split
);
  localparam int P_A = OVS / 2;
  localparam int P_B = P_A + 1;
  localparam int P_C = P_A + 2;

  logic samp_a_q, samp_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a_q <= 1'b1;
      samp_b_q <= 1'b1;
    end else if (tick && in_bit) begin
      if (rt == CW'(P_A)) samp_a_q <= line;
      if (rt == CW'(P_B)) samp_b_q <= line;
    end
  end

  assign vote_stb = tick && in_bit && (rt == CW'(P_C));
  assign vote     = (samp_a_q & samp_b_q) | (samp_a_q & line) | (samp_b_q & line);
  assign split    = !((samp_a_q == samp_b_q) && (samp_b_q == line));

  // R1: the vote is only taken while a bit is being received
  assert_vote_inside_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vote_stb |-> in_bit);
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int CW  = $clog2(OVS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          len9,
  input  logic          vote_stb,
  input  logic          vote,
  input  logic          split,
  output logic [CW-1:0] rt,
  output logic          in_bit,
  output logic          busy,
  output logic          done,
  output rx_frame_t     frame
);
  rx_state_e               state_q;
  logic [CW-1:0]           rt_q;
  logic [RX_IDX_W-1:0]     idx_q;
  logic [RX_MAX_BITS-1:0]  shreg_q;
  logic                    noisy_q;
  logic                    len9_q;
  logic                    prev_line_q;
  logic                    done_q;
  rx_frame_t               frame_q;
  logic [RX_IDX_W-1:0]     last_idx;
  logic                    bit_end;

  assign last_idx = len9_q ? RX_IDX_W'(RX_MAX_BITS - 1) : RX_IDX_W'(RX_BASE_BITS - 1);
  assign bit_end  = (rt_q == CW'(OVS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HUNT;
      rt_q        <= '0;
      idx_q       <= '0;
      shreg_q     <= '0;
      noisy_q     <= 1'b0;
      len9_q      <= 1'b0;
      prev_line_q <= 1'b1;
      done_q      <= 1'b0;
      frame_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        prev_line_q <= line;
        if (state_q != ST_HUNT) rt_q <= bit_end ? CW'(1) : rt_q + CW'(1);
        unique case (state_q)
          ST_HUNT: begin
            if (prev_line_q && !line) begin
              state_q <= ST_START;
              rt_q    <= CW'(2);
              idx_q   <= '0;
              shreg_q <= '0;
              noisy_q <= 1'b0;
              len9_q  <= len9;
            end
          end
          ST_START: begin
            if (vote_stb) begin
              if (vote) state_q <= ST_HUNT;
              else      noisy_q <= split;
            end else if (bit_end) begin
              state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (vote_stb) begin
              shreg_q[idx_q] <= vote;
              noisy_q        <= noisy_q | split;
            end else if (bit_end) begin
              if (idx_q == last_idx) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (vote_stb) begin
              state_q         <= ST_HUNT;
              done_q          <= 1'b1;
              frame_q.bits    <= shreg_q;
              frame_q.stop_ok <= vote;
              frame_q.noisy   <= noisy_q | split;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  // In HUNT, rt_q still holds its old value; the edge strobe itself is count 1.
  assign rt     = (state_q == ST_HUNT) ? CW'(1) : rt_q;
  assign in_bit = (state_q != ST_HUNT);
  assign busy   = (state_q != ST_HUNT);
  assign done   = done_q;
  assign frame  = frame_q;

  // R1: the sample counter stays inside one bit period while receiving
  assert_rt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_HUNT) |-> (rt_q >= CW'(1) && rt_q <= CW'(OVS)));
  // R2: a high start vote aborts the frame
  assert_false_start_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && vote_stb && vote) |=> (state_q == ST_HUNT && !done_q));
  // R11: busy ends right after the stop vote
  assert_busy_ends_at_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && vote_stb) |=> (!busy && done_q));
endmodule

// File: rtl/rx_result_reg.sv
module rx_result_reg
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   line,
  input  logic                   busy,
  input  logic                   len9,
  input  logic                   sleep_req,
  input  logic                   rd_ready,
  input  logic                   done,
  input  rx_frame_t              frame,
  output logic                   valid,
  output logic [RX_MAX_BITS-1:0] data,
  output logic                   fe,
  output logic                   ovr,
  output logic                   noise
);
  localparam int IDLE_LONG  = (RX_MAX_BITS + 2) * OVS;
  localparam int IDLE_SHORT = (RX_BASE_BITS + 2) * OVS;
  localparam int IW         = $clog2(IDLE_LONG + 1);

  logic                   standby_q;
  logic [IW-1:0]          idle_q;
  logic [IW-1:0]          idle_limit;
  logic                   valid_q, fe_q, ovr_q, noise_q;
  logic [RX_MAX_BITS-1:0] data_q;
  logic                   room;

  assign idle_limit = len9 ? IW'(IDLE_LONG - 1) : IW'(IDLE_SHORT - 1);
  assign room       = !valid_q || rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby_q <= 1'b0;
      idle_q    <= '0;
    end else if (sleep_req) begin
      standby_q <= 1'b1;
      idle_q    <= '0;
    end else if (standby_q && tick) begin
      if (!line) begin
        idle_q <= '0;
      end else if (!busy) begin
        if (idle_q == idle_limit) begin
          standby_q <= 1'b0;
          idle_q    <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (rd_ready) begin
        valid_q <= 1'b0;
        fe_q    <= 1'b0;
        ovr_q   <= 1'b0;
        noise_q <= 1'b0;
      end
      if (done) begin
        if (standby_q) begin
          data_q <= frame.bits;
        end else if (!room) begin
          ovr_q <= 1'b1;
        end else begin
          data_q  <= frame.bits;
          valid_q <= 1'b1;
          fe_q    <= !frame.stop_ok;
          noise_q <= frame.noisy;
        end
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign fe    = fe_q;
  assign ovr   = ovr_q;
  assign noise = noise_q;

  // R9: a dropped frame leaves the stored character untouched
  assert_overrun_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !standby_q && valid_q && !rd_ready) |=> ($stable(data_q) && ovr_q && valid_q));
  // R12: frames in standby never raise the full flag
  assert_standby_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && standby_q && !valid_q && !sleep_req) |=> !valid_q);
  // R6: a break yields a framed, zeroed, full register
  assert_break_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !standby_q && room && frame.bits == '0 && !frame.stop_ok)
      |=> (fe_q && valid_q && data_q == '0));
  // R10: a read with no completing frame leaves everything clear
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !done) |=> (!valid_q && !fe_q && !ovr_q && !noise_q));
endmodule

// File: rtl/serial_rx_ovs.sv
module serial_rx_ovs
  import serial_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       smp_tick,
  input  logic       len9,
  input  logic       sleep_req,
  input  logic       rie,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_bit8,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       err_noise,
  output logic       rx_busy,
  output logic       irq
);
  localparam int CW = $clog2(OVS + 1);

  logic                   line_s;
  logic [CW-1:0]          rt;
  logic                   in_bit;
  logic                   vote_stb, vote, split;
  logic                   busy, done;
  rx_frame_t              frame;
  logic                   valid;
  logic [RX_MAX_BITS-1:0] data;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  rx_vote_unit #(.OVS(OVS), .CW(CW)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(smp_tick), .in_bit(in_bit), .rt(rt),
    .line(line_s), .vote_stb(vote_stb), .vote(vote), .split(split)
  );

  rx_framer #(.OVS(OVS), .CW(CW)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(smp_tick), .line(line_s), .len9(len9),
    .vote_stb(vote_stb), .vote(vote), .split(split), .rt(rt), .in_bit(in_bit),
    .busy(busy), .done(done), .frame(frame)
  );

  rx_result_reg #(.OVS(OVS)) u_result (
    .clk(clk), .rst_n(rst_n), .tick(smp_tick), .line(line_s), .busy(busy),
    .len9(len9), .sleep_req(sleep_req), .rd_ready(rd_ready), .done(done),
    .frame(frame), .valid(valid), .data(data), .fe(err_frame),
    .ovr(err_overrun), .noise(err_noise)
  );

  assign rd_valid = valid;
  assign rd_data  = data[RX_BASE_BITS-1:0];
  assign rd_bit8  = data[RX_MAX_BITS-1];
  assign rx_busy  = busy;
  assign irq      = rie & valid;

  // R5: a read with interrupts enabled drops the request on the next cycle
  assert_irq_drops_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !done && rie && $stable(rie)) |=> !irq);
endmodule

// File: tb/serial_rx_ovs_test.sv
`timescale 1ns/1ps
module serial_rx_ovs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       smp_tick = 1'b0;
  logic       len9 = 1'b0;
  logic       sleep_req = 1'b0;
  logic       rie = 1'b0;
  logic       rd_ready = 1'b0;
  logic       rd_valid, rd_bit8, err_frame, err_overrun, err_noise, rx_busy, irq;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic busy_mid;

  always #2 clk = ~clk;

  serial_rx_ovs uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .smp_tick(smp_tick), .len9(len9),
    .sleep_req(sleep_req), .rie(rie), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_bit8(rd_bit8), .err_frame(err_frame),
    .err_overrun(err_overrun), .err_noise(err_noise), .rx_busy(rx_busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // One strobe period: new line value and a strobe, then strobe low.
  task automatic tp(input logic v);
    @(negedge clk); rxd = v; smp_tick = 1'b1;
    @(negedge clk); smp_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tp(1'b1);
  endtask

  // gb: bit position to corrupt (0 = start), -1 for none; gi: strobe index in it.
  task automatic send(input logic [8:0] d, input bit nine, input bit stop,
                      input int gb, input int gi);
    int nb = nine ? 9 : 8;
    for (int p = 0; p < nb + 2; p++) begin
      logic b;
      if (p == 0) b = 1'b0;
      else if (p == nb + 1) b = stop;
      else b = d[p-1];
      for (int i = 0; i < 16; i++) begin
        tp((p == gb && i == gi) ? ~b : b);
        if (p == nb + 1 && i == 2) busy_mid = rx_busy;
      end
    end
  endtask

  task automatic rd();
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic expect_frame(input string req, input logic [8:0] d,
                              input bit v, input bit fe, input bit nz, input bit ov);
    chk(rd_valid == v, req, "valid", rd_valid, v);
    chk({rd_bit8, rd_data} == d, req, "data", {rd_bit8, rd_data}, d);
    chk(err_frame == fe, req, "frame err", err_frame, fe);
    chk(err_noise == nz, req, "noise", err_noise, nz);
    chk(err_overrun == ov, req, "overrun", err_overrun, ov);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk(!rd_valid && !err_frame && !err_overrun && !err_noise && !rx_busy && !irq,
        "R10", "reset flags", {rd_valid, err_frame, err_overrun, err_noise, rx_busy}, 0);
    idle(20);

    // R4 R3: sweep of every 8-bit value
    for (int v = 0; v < 256; v++) begin
      send(9'(v) | 9'h100, 1'b0, 1'b1, -1, 0);
      checks++;
      if (!(rd_valid && {rd_bit8, rd_data} == 9'(v) && !err_frame && !err_noise && !err_overrun)) begin
        errors++;
        $display("FAIL R4 sweep8: got %0h expected %0h", {rd_bit8, rd_data}, v);
      end
      rd(); idle(2);
    end

    // R3: nine-bit frames, both values of the ninth bit
    len9 = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [8:0] d9 = {v[0], 8'(v * 37 + 5)};
      send(d9, 1'b1, 1'b1, -1, 0);
      chk(rd_valid && {rd_bit8, rd_data} == d9, "R3", "nine-bit data", {rd_bit8, rd_data}, d9);
      rd(); idle(2);
    end
    len9 = 1'b0;

    // R11: busy during stop bit, low afterwards
    send(9'h0A5, 1'b0, 1'b1, -1, 0);
    chk(busy_mid == 1'b1, "R11", "busy in frame", busy_mid, 1);
    chk(rx_busy == 1'b0, "R11", "busy after stop", rx_busy, 0);

    // R5: interrupt follows enable and full flag
    chk(irq == 1'b0, "R5", "irq disabled", irq, 0);
    rie = 1'b1; @(negedge clk);
    chk(irq == 1'b1, "R5", "irq enabled", irq, 1);
    rd();
    chk(irq == 1'b0, "R5", "irq after read", irq, 0);
    rie = 1'b0; idle(2);

    // R1 R8: glitch on sample 9 of data bit 2 -> data intact, noise set
    send(9'h0C3, 1'b0, 1'b1, 3, 8);
    expect_frame("R8", 9'h0C3, 1, 0, 1, 0);
    rd(); idle(2);
    // R1: glitches on samples 8 and 10 positions
    send(9'h03C, 1'b0, 1'b1, 5, 7);
    expect_frame("R1", 9'h03C, 1, 0, 1, 0);
    rd(); idle(2);
    send(9'h03C, 1'b0, 1'b1, 6, 9);
    expect_frame("R1", 9'h03C, 1, 0, 1, 0);
    rd(); idle(2);
    // R8: glitch outside the window -> no noise
    send(9'h081, 1'b0, 1'b1, 4, 12);
    expect_frame("R8", 9'h081, 1, 0, 0, 0);
    rd(); idle(2);
    // R1: glitch on the start bit's centre still accepted
    send(9'h055, 1'b0, 1'b1, 0, 8);
    expect_frame("R1", 9'h055, 1, 0, 1, 0);
    rd(); idle(2);

    // R2: short low pulse is rejected
    for (int i = 0; i < 4; i++) tp(1'b0);
    chk(rx_busy == 1'b1, "R2", "edge detected", rx_busy, 1);
    idle(40);
    chk(rx_busy == 1'b0 && rd_valid == 1'b0, "R2", "false start",
        {rx_busy, rd_valid}, 0);

    // R7: framing error with data
    send(9'h04E, 1'b0, 1'b0, -1, 0);
    expect_frame("R7", 9'h04E, 1, 1, 0, 0);
    idle(4);
    rd(); idle(2);
    // R10: read clears flags
    expect_frame("R10", 9'h04E, 0, 0, 0, 0);

    // R6: break in both lengths
    send(9'h000, 1'b0, 1'b0, -1, 0);
    idle(4);
    expect_frame("R6", 9'h000, 1, 1, 0, 0);
    rd(); idle(2);
    send(9'h1FF, 1'b1, 1'b1, -1, 0);
    rd(); idle(2);
    len9 = 1'b1;
    send(9'h000, 1'b1, 1'b0, -1, 0);
    idle(4);
    expect_frame("R6", 9'h000, 1, 1, 0, 0);
    rd(); idle(2);
    len9 = 1'b0;

    // R9: overrun keeps the first character
    send(9'h011, 1'b0, 1'b1, -1, 0);
    idle(2);
    send(9'h022, 1'b0, 1'b1, -1, 0);
    expect_frame("R9", 9'h011, 1, 0, 0, 1);
    rd(); idle(2);
    expect_frame("R10", 9'h011, 0, 0, 0, 0);

    // R12: standby loads data silently
    @(negedge clk); sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    idle(16);
    send(9'h05A, 1'b0, 1'b1, -1, 0);
    expect_frame("R12", 9'h05A, 0, 0, 0, 0);
    send(9'h000, 1'b0, 1'b0, -1, 0);
    idle(80);
    expect_frame("R12", 9'h000, 0, 0, 0, 0);
    // R13: a short gap is not enough
    send(9'h033, 1'b0, 1'b1, -1, 0);
    idle(150);
    send(9'h044, 1'b0, 1'b1, -1, 0);
    expect_frame("R13", 9'h044, 0, 0, 0, 0);
    // R13: a full 8-bit idle character wakes the receiver
    idle(166);
    send(9'h077, 1'b0, 1'b1, -1, 0);
    expect_frame("R13", 9'h077, 1, 0, 0, 0);
    rd(); idle(2);

    // R13: in 9-bit mode 166 strobes is too short, 186 is enough
    len9 = 1'b1;
    @(negedge clk); sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    idle(166);
    send(9'h1A5, 1'b1, 1'b1, -1, 0);
    expect_frame("R13", 9'h1A5, 0, 0, 0, 0);
    idle(186);
    send(9'h15A, 1'b1, 1'b1, -1, 0);
    expect_frame("R13", 9'h15A, 1, 0, 0, 0);
    rd(); idle(2);
    len9 = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule